// File: doc/BRIEF.md
# Stride-3 Compressed Trie Node Lookup

This block resolves one level of a multibit routing trie whose nodes consume three address bits each. Instead of holding a pointer per possible prefix, a node carries a 7-bit occupancy bitmap and an 8-bit base index. The bitmap marks which prefixes of length 0, 1 and 2 inside the node exist. The next hops of those prefixes sit back to back in a packed list that starts at the base index.

Given the node's bitmap, its base and the three address bits for this level, the block picks the longest prefix held in the node that covers the address. It counts how many occupied positions come before that prefix in the bitmap and adds this rank to the base to form the next-hop address. It also raises a hit flag. The result is available combinationally in the same cycle. A registered copy, qualified by a valid strobe, follows one cycle later, so the block can sit in a pipelined lookup path.

Top module: `trie_node_lookup`

## Requirements
- R1: Bitmap positions are breadth-first. Position 0 is the empty prefix, positions 1 and 2 are the one-bit prefixes 0 and 1, and positions 3 to 6 are the two-bit prefixes 00, 01, 10 and 11. The prefix bits are taken from the address MSB downward.
- R2: Of the candidate positions that cover the address, the block selects the set one with the longest prefix. The candidates are checked in order of length 2, then length 1, then length 0.
- R3: When no candidate position is set, `hit_now` is 0 and `nh_addr_now` is 0.
- R4: On a hit, `nh_addr_now` equals `node_base` plus the number of set bitmap bits at positions strictly below the selected position.
- R5: The sum in R4 wraps modulo 256. For example, base 252 plus rank 6 gives 2.
- R6: When `lookup_valid` is 1 at a rising edge, the next cycle shows `res_valid` = 1, and `res_hit` and `res_nh_addr` equal the combinational results of that edge.
- R7: When `lookup_valid` is 0 at a rising edge, `res_valid` drops to 0 and `res_hit` and `res_nh_addr` keep their previous values.
- R8: A synchronous active-high reset clears `res_valid`, `res_hit` and `res_nh_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | Marks the inputs of this cycle as a lookup to register |
| node_bitmap | input | 7 | Breadth-first occupancy bitmap of the node |
| node_base | input | 8 | Start of the node's packed next-hop list |
| addr_bits | input | 3 | Address bits consumed at this level, MSB first |
| hit_now | output | 1 | Combinational hit flag |
| nh_addr_now | output | 8 | Combinational next-hop address |
| res_valid | output | 1 | Registered result valid |
| res_hit | output | 1 | Registered hit flag |
| res_nh_addr | output | 8 | Registered next-hop address |

## Verification
The interesting overlap is between longest-match selection and the modulo-256 addition. The rank is largest when the selected prefix is deep and many shallower positions are also occupied, and that is exactly when the base sum wraps. The bench sweeps every bitmap against every address, with bases chosen so that many lookups land near 255. It compares the address after wrap-around with a value computed by scanning the bitmap arithmetically. Every combinational result is also checked again one cycle later at the registered outputs.

// File: rtl/trie_node_pkg.sv
package trie_node_pkg;

  // Number of internal prefix positions in a node of the given stride.
  function automatic int node_positions(input int stride);
    return (1 << stride) - 1;
  endfunction

  // First breadth-first position used by prefixes of length len.
  function automatic int level_offset(input int len);
    return (1 << len) - 1;
  endfunction

endpackage

// File: rtl/trie_cand_select.sv
module trie_cand_select
  import trie_node_pkg::*;
#(
  parameter int STRIDE = 3,
  parameter int NPOS   = node_positions(STRIDE),
  parameter int POS_W  = $clog2(NPOS)
) (
  input  logic [NPOS-1:0]   bitmap,
  input  logic [STRIDE-1:0] addr_bits,
  output logic              found,
  output logic [POS_W-1:0]  match_pos
);

  logic [POS_W-1:0] cand_pos [STRIDE];
  logic [STRIDE-1:0] cand_hit;

  // One candidate position per prefix length 0 .. STRIDE-1
  for (genvar len = 0; len < STRIDE; len++) begin : g_level
    always_comb begin
      cand_pos[len] = POS_W'(level_offset(len))
                    + POS_W'({1'b0, addr_bits} >> (STRIDE - len));
      cand_hit[len] = bitmap[cand_pos[len]];
    end
  end

  // Longer prefixes override shorter ones
  always_comb begin
    found     = 1'b0;
    match_pos = '0;
    for (int len = 0; len < STRIDE; len++) begin
      if (cand_hit[len]) begin
        found     = 1'b1;
        match_pos = cand_pos[len];
      end
    end
  end

endmodule

// File: rtl/trie_rank_count.sv
module trie_rank_count #(
  parameter int NPOS  = 7,
  parameter int POS_W = $clog2(NPOS),
  parameter int CNT_W = $clog2(NPOS + 1)
) (
  input  logic [NPOS-1:0]  bitmap,
  input  logic [POS_W-1:0] pos,
  output logic [CNT_W-1:0] rank
);

  logic [NPOS-1:0] below;

  for (genvar i = 0; i < NPOS; i++) begin : g_mask
    assign below[i] = bitmap[i] && (POS_W'(i) < pos);
  end

  always_comb begin
    rank = '0;
    for (int i = 0; i < NPOS; i++) begin
      rank = rank + CNT_W'(below[i]);
    end
  end

endmodule

// File: rtl/trie_out_reg.sv
module trie_out_reg #(
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              hit_d,
  input  logic [BASE_W-1:0] addr_d,
  output logic              valid_q,
  output logic              hit_q,
  output logic [BASE_W-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= load;
      if (load) begin
        hit_q  <= hit_d;
        addr_q <= addr_d;
      end
    end
  end

endmodule

// File: rtl/trie_node_lookup.sv
module trie_node_lookup
  import trie_node_pkg::*;
#(
  parameter int STRIDE = 3,
  parameter int BASE_W = 8,
  localparam int NPOS  = node_positions(STRIDE),
  localparam int POS_W = $clog2(NPOS),
  localparam int CNT_W = $clog2(NPOS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lookup_valid,
  input  logic [NPOS-1:0]   node_bitmap,
  input  logic [BASE_W-1:0] node_base,
  input  logic [STRIDE-1:0] addr_bits,
  output logic              hit_now,
  output logic [BASE_W-1:0] nh_addr_now,
  output logic              res_valid,
  output logic              res_hit,
  output logic [BASE_W-1:0] res_nh_addr
);

  logic [POS_W-1:0] match_pos;
  logic [CNT_W-1:0] rank;

  trie_cand_select #(
    .STRIDE (STRIDE),
    .NPOS   (NPOS),
    .POS_W  (POS_W)
  ) u_select (
    .bitmap    (node_bitmap),
    .addr_bits (addr_bits),
    .found     (hit_now),
    .match_pos (match_pos)
  );

  trie_rank_count #(
    .NPOS  (NPOS),
    .POS_W (POS_W),
    .CNT_W (CNT_W)
  ) u_rank (
    .bitmap (node_bitmap),
    .pos    (match_pos),
    .rank   (rank)
  );

  // Packed list: base plus rank, wrapping at the index width
  assign nh_addr_now = hit_now ? (node_base + BASE_W'(rank)) : '0;

  trie_out_reg #(
    .BASE_W (BASE_W)
  ) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .load    (lookup_valid),
    .hit_d   (hit_now),
    .addr_d  (nh_addr_now),
    .valid_q (res_valid),
    .hit_q   (res_hit),
    .addr_q  (res_nh_addr)
  );

endmodule

// File: rtl/trie_node_lookup_chk.sv
module trie_node_lookup_chk #(
  parameter int NPOS   = 7,
  parameter int BASE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              lookup_valid,
  input logic [NPOS-1:0]   node_bitmap,
  input logic              hit_now,
  input logic [BASE_W-1:0] nh_addr_now,
  input logic              res_valid,
  input logic              res_hit,
  input logic [BASE_W-1:0] res_nh_addr
);

  AST_ROOT_ALWAYS_HITS: assert property (@(posedge clk) disable iff (rst)
    node_bitmap[0] |-> hit_now); // R2

  AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    !hit_now |-> (nh_addr_now == '0)); // R3

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> res_valid); // R6

  AST_REG_MATCHES_COMB: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> (res_hit == $past(hit_now)) && (res_nh_addr == $past(nh_addr_now))); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !lookup_valid |=> !res_valid && $stable(res_hit) && $stable(res_nh_addr)); // R7

endmodule

bind trie_node_lookup trie_node_lookup_chk #(
  .NPOS   (NPOS),
  .BASE_W (BASE_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lookup_valid (lookup_valid),
  .node_bitmap  (node_bitmap),
  .hit_now      (hit_now),
  .nh_addr_now  (nh_addr_now),
  .res_valid    (res_valid),
  .res_hit      (res_hit),
  .res_nh_addr  (res_nh_addr)
);

// File: tb/test_trie_node_lookup.sv
module test_trie_node_lookup;

  logic       clk = 1'b0;
  logic       rst;
  logic       lookup_valid;
  logic [6:0] node_bitmap;
  logic [7:0] node_base;
  logic [2:0] addr_bits;
  logic       hit_now;
  logic [7:0] nh_addr_now;
  logic       res_valid;
  logic       res_hit;
  logic [7:0] res_nh_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  trie_node_lookup i_trie_node_lookup (
    .clk          (clk),
    .rst          (rst),
    .lookup_valid (lookup_valid),
    .node_bitmap  (node_bitmap),
    .node_base    (node_base),
    .addr_bits    (addr_bits),
    .hit_now      (hit_now),
    .nh_addr_now  (nh_addr_now),
    .res_valid    (res_valid),
    .res_hit      (res_hit),
    .res_nh_addr  (res_nh_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Arithmetic model: scan lengths 2, 1, 0; position = 2^len - 1 + top len bits
  function automatic void model(input int bm, input int a, input int b,
                                output int hit, output int nh);
    int pos;
    int rank;
    hit = 0;
    nh  = 0;
    pos = -1;
    for (int len = 2; len >= 0; len--) begin
      int p;
      p = (1 << len) - 1 + (a >> (3 - len));
      if (pos < 0 && ((bm >> p) & 1) == 1) pos = p;
    end
    if (pos >= 0) begin
      rank = 0;
      for (int i = 0; i < pos; i++) rank += (bm >> i) & 1;
      hit = 1;
      nh  = (b + rank) % 256;
    end
  endfunction

  initial begin
    int ph, pn;
    int eh, en;
    bit have_prev;
    rst = 1'b1;
    lookup_valid = 1'b0;
    node_bitmap = '0;
    node_base = '0;
    addr_bits = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", res_valid, 0);
    check("R8", res_hit, 0);
    check("R8", res_nh_addr, 0);
    rst = 1'b0;

    // R1: single occupied position hits only the address it covers
    for (int p = 0; p < 7; p++) begin
      for (int a = 0; a < 8; a++) begin
        int len, cov;
        @(negedge clk);
        node_bitmap = 7'(1 << p);
        node_base = 8'd40;
        addr_bits = 3'(a);
        #1;
        len = (p == 0) ? 0 : (p < 3 ? 1 : 2);
        cov = ((1 << len) - 1 + (a >> (3 - len))) == p;
        check("R1", hit_now, cov);
        check("R1", nh_addr_now, cov ? 40 : 0);
      end
    end

    // R2 R3 R4 R5 R6: full sweep with registered copy checked a cycle later
    have_prev = 0;
    ph = 0;
    pn = 0;
    for (int bm = 0; bm < 128; bm++) begin
      for (int a = 0; a < 8; a++) begin
        int b;
        @(negedge clk);
        if (have_prev) begin
          check("R6", res_valid, 1);
          check("R6", res_hit, ph);
          check("R6", res_nh_addr, pn);
        end
        b = (bm % 4 == 0) ? (250 + a) % 256 : (bm * 37 + a * 11) % 256;
        node_bitmap = 7'(bm);
        addr_bits = 3'(a);
        node_base = 8'(b);
        lookup_valid = 1'b1;
        #1;
        model(bm, a, b, eh, en);
        if (eh == 0) begin
          check("R3", hit_now, 0);
          check("R3", nh_addr_now, 0);
        end else if (b + en < 256 && en < b) begin
          check("R5", hit_now, 1);
          check("R5", nh_addr_now, en);
        end else begin
          check("R2", hit_now, 1);
          check("R4", nh_addr_now, en);
        end
        ph = eh;
        pn = en;
        have_prev = 1;
      end
    end

    // R5: directed wrap case, full bitmap, deepest position, rank 6
    @(negedge clk);
    node_bitmap = 7'h7F;
    addr_bits = 3'b111;
    node_base = 8'd252;
    #1;
    check("R5", nh_addr_now, 2);
    // R2: 10 and 1 both set for address 101, longer one wins (rank 1 of 2 bits)
    @(negedge clk);
    node_bitmap = 7'b0100100;
    addr_bits = 3'b101;
    node_base = 8'd10;
    #1;
    check("R2", nh_addr_now, 11);
    model(7'b0100100, 5, 10, eh, en);

    // R7: idle cycles leave registered results untouched
    @(negedge clk);
    check("R6", res_nh_addr, en);
    lookup_valid = 1'b0;
    node_bitmap = 7'h01;
    node_base = 8'd99;
    @(negedge clk);
    check("R7", res_valid, 0);
    check("R7", res_hit, 1);
    check("R7", res_nh_addr, en);
    @(negedge clk);
    check("R7", res_nh_addr, en);

    // R8: reset mid-run clears results
    rst = 1'b1;
    @(negedge clk);
    check("R8", res_hit, 0);
    check("R8", res_nh_addr, 0);
    rst = 1'b0;
    done = 1;
  end

  initial begin
    for (int cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule